// File: doc/BRIEF.md
# Banked Interrupt Distributor

This block sits between a set of interrupt sources and a small cluster of processors. For every interrupt line it keeps an enable bit, a trigger mode, an 8-bit priority and a byte-wide mask of target processors. It records pending state from the raw inputs and drives one request output per processor. A processor's request is high while forwarding is switched on and at least one enabled, pending line is routed to that processor. Priority values are only stored here. Choosing between requests and acknowledging them is left to a per-processor interface outside this block.

Lines 0 to 31 are private to each processor. Every processor has its own 32 input pins for them, and its own copy of their enable bits and pending latches. All of these copies appear at the same register address, and the requester tag on the register port picks which copy is accessed. Lines 32 and above are shared and routed by their target byte. Register accesses are single-cycle. A write takes effect at the clock edge where it is sampled. Read data is combinational while `reg_rd` is high and zero otherwise. `NUM_LINES` must be a multiple of 32 from 64 to 1024, and `NUM_CPUS` must be from 1 to 8.

Top module: `irqd_dist`

## Requirements
- R1: After reset, forwarding is off, every enable bit is 0, every priority byte is 0, every shared target byte is 0, shared lines are level-triggered and `cpu_irq` is all zero.
- R2: Enable bits have a set view at byte 0x100+4w and a clear view at 0x180+4w. A 1 written to the set view turns that line on, and a 1 written to the clear view turns it off. A 0 bit leaves the line unchanged. Both views read back the present enable bits.
- R3: Line n's enable and pending bits are bit n%32 of word n/32. Word 0 holds the private lines and word 1 onward holds the shared lines.
- R4: Private lines 0-31 keep one enable copy and one pending copy per processor. An access tagged with processor c through `reg_cpu` reads and writes only the copy of c. A private input pin `irq_local[32*c+i]` affects only processor c.
- R5: Trigger mode uses two bits per line, with 16 lines in each word at 0xC00+4w. Bit 2*(n%16)+1 set to 1 selects rising-edge mode for line n, and 0 selects level-high mode. The lower bit of each pair reads 0. Lines 0-15 are always edge-triggered, so word 0xC00 reads 0xAAAAAAAA and ignores writes.
- R6: Priority byte n%4 of word 0x400+4*(n/4) holds line n's priority and reads back what was last written.
- R7: For shared lines, the target byte n%4 of word 0x800+4*(n/4) holds line n's processor mask, with bit c standing for processor c. For private lines the target bytes read as the requester's own bit and ignore writes.
- R8: The word at 0x004 is read-only. Its bits [4:0] read NUM_LINES/32-1 and its remaining bits read 0.
- R9: Bit 0 of the word at 0x000 switches forwarding on. While it is 0, every `cpu_irq` bit is 0.
- R10: A level-mode line is pending exactly while its input is high. An edge-mode line latches pending on a 0-to-1 input change and stays pending until a 1 is written to its bit in the pending-clear word at 0x280+4w. The pending state reads at 0x200+4w.
- R11: `cpu_irq[c]` is 1 when forwarding is on and some line is both enabled and pending, where that line is either a shared line whose target bit c is 1, or a private line in processor c's own copy.
- R12: If a rising edge on an edge-mode line and a pending-clear write to that same line fall in the same cycle, the line remains pending.
- R13: An access tagged with a processor number of NUM_CPUS or higher reads 0 from the private enable and pending words, and its writes to those words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | 3 | Number of the processor making the access |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq_local | input | NUM_CPUS*32 | Private line inputs, 32 per processor |
| irq_shared | input | NUM_LINES-32 | Shared line inputs, bit j is line 32+j |
| cpu_irq | output | NUM_CPUS | Request output per processor |

## Verification
Edge capture and software clearing of the pending latch can land on the same clock edge. The bench provokes this by raising an edge-mode shared input in the same cycle as a pending-clear write to that line. It then checks that the processor's request stays high and that the pending word still shows the bit. A second pending-clear, issued while the input stays high, must then drop the bit, which shows that the clear itself does work.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // register window selected by the upper address bits
    typedef enum logic [3:0] {
        RG_NONE,
        RG_SYS,
        RG_ENSET,
        RG_ENCLR,
        RG_PEND,
        RG_PCLR,
        RG_PRIO,
        RG_TGT,
        RG_CFG
    } region_e;

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [7:0]        widx
);
    always_comb begin
        region = RG_NONE;
        widx   = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr[11:7] == 5'b00000) begin
                region = RG_SYS;
                widx   = {3'b000, addr[6:2]};
            end else if (addr[11:7] == 5'b00010) begin
                region = RG_ENSET;
                widx   = {3'b000, addr[6:2]};
            end else if (addr[11:7] == 5'b00011) begin
                region = RG_ENCLR;
                widx   = {3'b000, addr[6:2]};
            end else if (addr[11:7] == 5'b00100) begin
                region = RG_PEND;
                widx   = {3'b000, addr[6:2]};
            end else if (addr[11:7] == 5'b00101) begin
                region = RG_PCLR;
                widx   = {3'b000, addr[6:2]};
            end else if (addr[11:10] == 2'b01) begin
                region = RG_PRIO;
                widx   = addr[9:2];
            end else if (addr[11:10] == 2'b10) begin
                region = RG_TGT;
                widx   = addr[9:2];
            end else if (addr[11:8] == 4'hC) begin
                region = RG_CFG;
                widx   = {2'b00, addr[7:2]};
            end
        end
    end
endmodule

// File: rtl/irqd_edge.sv
module irqd_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
        rise   = sig_in & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqd_fwd.sv
module irqd_fwd #(
    parameter int NUM_CPUS = 4,
    parameter int SHR      = 32
) (
    input  logic                       fwd_en,
    input  logic [NUM_CPUS-1:0][31:0]  en_bank,
    input  logic [NUM_CPUS-1:0][31:0]  pe_bank,
    input  logic [SHR-1:0]             en_shr,
    input  logic [SHR-1:0]             pe_shr,
    input  logic [SHR-1:0][7:0]        tgt,
    output logic [NUM_CPUS-1:0]        irq
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic hit;
        always_comb begin
            hit = |(en_bank[c] & pe_bank[c]);
            for (int j = 0; j < SHR; j++) begin
                if (en_shr[j] && pe_shr[j] && tgt[j][c]) hit = 1'b1;
            end
            irq[c] = fwd_en & hit;
        end
    end
endmodule

// File: rtl/irqd_dist.sv
module irqd_dist
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [11:0]             reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [2:0]              reg_cpu,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_CPUS*32-1:0]  irq_local,
    input  logic [NUM_LINES-33:0]   irq_shared,
    output logic [NUM_CPUS-1:0]     cpu_irq
);
    localparam int SHR = NUM_LINES - 32;
    localparam int EN_WORDS = NUM_LINES / 32;
    localparam logic [4:0] TYPE_N = 5'(EN_WORDS - 1);

    typedef struct packed {
        logic                      ctrl_en;
        logic [NUM_CPUS-1:0][31:0] en_bank;
        logic [SHR-1:0]            en_shr;
        logic [NUM_LINES-1:0]      cfg_edge;
        logic [NUM_LINES-1:0][7:0] prio;
        logic [SHR-1:0][7:0]       tgt;
        logic [NUM_CPUS-1:0][31:0] pl_bank;
        logic [SHR-1:0]            pl_shr;
    } dist_st_t;

    dist_st_t st_d, st_q;

    region_e    region;
    logic [7:0] widx;

    logic [NUM_CPUS*32-1:0]    rise_loc;
    logic [SHR-1:0]            rise_shr;
    logic [NUM_CPUS-1:0][31:0] pe_bank;
    logic [SHR-1:0]            pe_shr;
    logic [NUM_CPUS-1:0][31:0] clr_bank;
    logic [SHR-1:0]            clr_shr;
    logic [NUM_CPUS-1:0]       sel;

    irqd_decode u_dec (
        .addr   (reg_addr),
        .region (region),
        .widx   (widx)
    );

    irqd_edge #(.WIDTH(NUM_CPUS*32)) u_edge_loc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (irq_local),
        .rise   (rise_loc)
    );

    irqd_edge #(.WIDTH(SHR)) u_edge_shr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (irq_shared),
        .rise   (rise_shr)
    );

    // requester select: only valid processor numbers reach a private copy
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) sel[c] = (int'(reg_cpu) == c);
    end

    // effective pending: level lines follow the pin, edge lines use the latch
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int i = 0; i < 32; i++) begin
                pe_bank[c][i] = st_q.cfg_edge[i] ? st_q.pl_bank[c][i] : irq_local[c*32+i];
            end
        end
        for (int j = 0; j < SHR; j++) begin
            pe_shr[j] = st_q.cfg_edge[32+j] ? st_q.pl_shr[j] : irq_shared[j];
        end
    end

    // pending-clear masks from the register port
    always_comb begin
        clr_bank = '0;
        clr_shr  = '0;
        if (reg_wr && region == RG_PCLR) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (sel[c] && widx == 8'd0) clr_bank[c] = reg_wdata;
            end
            for (int j = 0; j < SHR; j++) begin
                if (int'(widx) == (32 + j) / 32) clr_shr[j] = reg_wdata[(32 + j) % 32];
            end
        end
    end

    // next-state computation
    always_comb begin
        st_d = st_q;

        // edge latches: a new rising edge beats a clear in the same cycle
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int i = 0; i < 32; i++) begin
                st_d.pl_bank[c][i] = st_q.cfg_edge[i]
                    ? ((st_q.pl_bank[c][i] & ~clr_bank[c][i]) | rise_loc[c*32+i])
                    : 1'b0;
            end
        end
        for (int j = 0; j < SHR; j++) begin
            st_d.pl_shr[j] = st_q.cfg_edge[32+j]
                ? ((st_q.pl_shr[j] & ~clr_shr[j]) | rise_shr[j])
                : 1'b0;
        end

        if (reg_wr) begin
            case (region)
                RG_SYS: begin
                    if (widx == 8'd0) st_d.ctrl_en = reg_wdata[0];
                end
                RG_ENSET, RG_ENCLR: begin
                    for (int c = 0; c < NUM_CPUS; c++) begin
                        if (sel[c] && widx == 8'd0) begin
                            if (region == RG_ENSET) st_d.en_bank[c] = st_q.en_bank[c] | reg_wdata;
                            else                    st_d.en_bank[c] = st_q.en_bank[c] & ~reg_wdata;
                        end
                    end
                    for (int j = 0; j < SHR; j++) begin
                        if (int'(widx) == (32 + j) / 32 && reg_wdata[(32 + j) % 32]) begin
                            st_d.en_shr[j] = (region == RG_ENSET);
                        end
                    end
                end
                RG_PRIO: begin
                    for (int l = 0; l < NUM_LINES; l++) begin
                        if (int'(widx) == l / 4) st_d.prio[l] = reg_wdata[8*(l%4) +: 8];
                    end
                end
                RG_TGT: begin
                    for (int j = 0; j < SHR; j++) begin
                        if (int'(widx) == (32 + j) / 4) st_d.tgt[j] = reg_wdata[8*((32 + j) % 4) +: 8];
                    end
                end
                RG_CFG: begin
                    for (int l = 16; l < NUM_LINES; l++) begin
                        if (int'(widx) == l / 16) st_d.cfg_edge[l] = reg_wdata[2*(l%16)+1];
                    end
                end
                default: ;
            endcase
        end

        // lines 0-15 are permanently edge-triggered
        st_d.cfg_edge[15:0] = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q                 <= '0;
            st_q.cfg_edge[15:0]  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (region)
                RG_SYS: begin
                    if (widx == 8'd0)      reg_rdata = {31'b0, st_q.ctrl_en};
                    else if (widx == 8'd1) reg_rdata = {27'b0, TYPE_N};
                end
                RG_ENSET, RG_ENCLR: begin
                    for (int c = 0; c < NUM_CPUS; c++) begin
                        if (sel[c] && widx == 8'd0) reg_rdata = st_q.en_bank[c];
                    end
                    for (int j = 0; j < SHR; j++) begin
                        if (int'(widx) == (32 + j) / 32) reg_rdata[(32 + j) % 32] = st_q.en_shr[j];
                    end
                end
                RG_PEND, RG_PCLR: begin
                    for (int c = 0; c < NUM_CPUS; c++) begin
                        if (sel[c] && widx == 8'd0) reg_rdata = pe_bank[c];
                    end
                    for (int j = 0; j < SHR; j++) begin
                        if (int'(widx) == (32 + j) / 32) reg_rdata[(32 + j) % 32] = pe_shr[j];
                    end
                end
                RG_PRIO: begin
                    for (int l = 0; l < NUM_LINES; l++) begin
                        if (int'(widx) == l / 4) reg_rdata[8*(l%4) +: 8] = st_q.prio[l];
                    end
                end
                RG_TGT: begin
                    for (int l = 0; l < 32; l++) begin
                        for (int c = 0; c < NUM_CPUS; c++) begin
                            if (int'(widx) == l / 4 && sel[c]) reg_rdata[8*(l%4)+c] = 1'b1;
                        end
                    end
                    for (int j = 0; j < SHR; j++) begin
                        if (int'(widx) == (32 + j) / 4) reg_rdata[8*((32 + j) % 4) +: 8] = st_q.tgt[j];
                    end
                end
                RG_CFG: begin
                    for (int l = 0; l < NUM_LINES; l++) begin
                        if (int'(widx) == l / 16) reg_rdata[2*(l%16)+1] = st_q.cfg_edge[l];
                    end
                end
                default: ;
            endcase
        end
    end

    irqd_fwd #(.NUM_CPUS(NUM_CPUS), .SHR(SHR)) u_fwd (
        .fwd_en  (st_q.ctrl_en),
        .en_bank (st_q.en_bank),
        .pe_bank (pe_bank),
        .en_shr  (st_q.en_shr),
        .pe_shr  (pe_shr),
        .tgt     (st_q.tgt),
        .irq     (cpu_irq)
    );
endmodule

// File: rtl/irqd_dist_chk.sv
module irqd_dist_chk #(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [11:0]         reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [2:0]          reg_cpu,
    input logic [31:0]         reg_rdata,
    input logic [NUM_CPUS-1:0] cpu_irq
);
    // shadow of the forwarding switch, built from port traffic only
    logic ctl_sh;
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctl_sh <= 1'b0;
        else if (reg_wr && reg_addr == 12'h000)  ctl_sh <= reg_wdata[0];
    end

    assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_sh |-> cpu_irq == '0);

    assert_type_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 12'h004) |-> reg_rdata == {27'b0, 5'(NUM_LINES/32 - 1)});

    assert_sgi_cfg_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 12'hC00) |-> reg_rdata == 32'hAAAA_AAAA);

    assert_prio_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[11:10] == 2'b01 && reg_addr[1:0] == 2'b00
         && int'(reg_addr[9:2]) < NUM_LINES/4)
        |=> ((reg_rd && !reg_wr && reg_addr == $past(reg_addr)) |-> reg_rdata == $past(reg_wdata)));

    assert_bad_requester_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && int'(reg_cpu) >= NUM_CPUS && reg_addr == 12'h100) |-> reg_rdata == 32'h0);
endmodule

bind irqd_dist irqd_dist_chk #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_cpu   (reg_cpu),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/irqd_dist_tb_top.sv
module irqd_dist_tb_top;
    localparam int NL = 64;
    localparam int NC = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [11:0]      reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [2:0]       reg_cpu = '0;
    logic [31:0]      reg_rdata;
    logic [NC*32-1:0] irq_local = '0;
    logic [NL-33:0]   irq_shared = '0;
    logic [NC-1:0]    cpu_irq;

    irqd_dist #(.NUM_LINES(NL), .NUM_CPUS(NC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_cpu    (reg_cpu),
        .reg_rdata  (reg_rdata),
        .irq_local  (irq_local),
        .irq_shared (irq_shared),
        .cpu_irq    (cpu_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_cpu = cpu; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chkrd(input string req, input logic [2:0] cpu, input logic [11:0] a,
                         input logic [31:0] exp);
        logic [31:0] v;
        reg_cpu = cpu; reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, v, exp);
    endtask

    task automatic chkirq(input string req, input logic [NC-1:0] exp);
        #1 check(req, 32'(cpu_irq), 32'(exp));
    endtask

    task automatic t_reset;
        chkrd("R1 ctrl", 0, 12'h000, 32'h0);
        chkrd("R1 shared enable", 0, 12'h104, 32'h0);
        chkrd("R1 priority", 0, 12'h420, 32'h0);
        chkrd("R1 target", 0, 12'h820, 32'h0);
        chkrd("R1 shared cfg level", 0, 12'hC08, 32'h0);
        chkirq("R1 outputs", '0);
    endtask

    task automatic t_type;
        chkrd("R8 type word", 0, 12'h004, 32'h1);
    endtask

    task automatic t_enable;
        wr(0, 12'h104, 32'h5);
        chkrd("R2 set view", 0, 12'h104, 32'h5);
        chkrd("R2 clear view reads", 0, 12'h184, 32'h5);
        wr(0, 12'h184, 32'h1);
        chkrd("R2 clear one bit", 0, 12'h104, 32'h4);
        wr(0, 12'h104, 32'h0);
        chkrd("R2 zero to set view", 0, 12'h104, 32'h4);
        wr(0, 12'h184, 32'h0);
        chkrd("R2 zero to clear view", 0, 12'h104, 32'h4);
        chkrd("R3 shared not in word 0", 0, 12'h100, 32'h0);
        wr(0, 12'h184, 32'hFFFF_FFFF);
        chkrd("R2 clear all", 0, 12'h104, 32'h0);
    endtask

    task automatic t_bank;
        wr(1, 12'h100, 32'h0001_0003);
        chkrd("R4 own copy", 1, 12'h100, 32'h0001_0003);
        chkrd("R4 other copy", 2, 12'h100, 32'h0);
        wr(5, 12'h100, 32'hF);
        chkrd("R13 bad requester reads 0", 5, 12'h100, 32'h0);
        chkrd("R13 bad write no effect", 1, 12'h100, 32'h0001_0003);
        chkrd("R13 bad write cpu0", 0, 12'h100, 32'h0);
        wr(1, 12'h180, 32'hFFFF_FFFF);
        chkrd("R4 clear own copy", 1, 12'h100, 32'h0);
    endtask

    task automatic t_cfg;
        chkrd("R5 fixed word", 0, 12'hC00, 32'hAAAA_AAAA);
        wr(0, 12'hC00, 32'h0);
        chkrd("R5 fixed ignores write", 0, 12'hC00, 32'hAAAA_AAAA);
        wr(0, 12'hC04, 32'hFFFF_FFFF);
        chkrd("R5 low bit of pair reads 0", 0, 12'hC04, 32'hAAAA_AAAA);
        wr(0, 12'hC04, 32'h0);
        wr(0, 12'hC08, 32'h0000_0008);
        chkrd("R5 line 33 edge", 0, 12'hC08, 32'h0000_0008);
    endtask

    task automatic t_prio;
        wr(0, 12'h420, 32'h1122_3344);
        chkrd("R6 priority readback", 0, 12'h420, 32'h1122_3344);
        wr(0, 12'h404, 32'h0000_A000);
        chkrd("R6 private line priority", 2, 12'h404, 32'h0000_A000);
    endtask

    task automatic t_target;
        wr(0, 12'h820, 32'h0000_0204);
        chkrd("R7 shared target", 0, 12'h820, 32'h0000_0204);
        chkrd("R7 private target cpu3", 3, 12'h800, 32'h0808_0808);
        wr(3, 12'h800, 32'hFFFF_FFFF);
        chkrd("R7 private target ignores write", 3, 12'h800, 32'h0808_0808);
        chkrd("R7 private target cpu1", 1, 12'h81C, 32'h0202_0202);
    endtask

    task automatic t_level;
        wr(0, 12'h104, 32'h1);
        @(negedge clk);
        irq_shared[0] = 1'b1;
        chkirq("R9 forwarding off", '0);
        wr(0, 12'h000, 32'h1);
        chkirq("R11 level line to cpu2", 4'b0100);
        chkrd("R10 level pending", 0, 12'h204, 32'h1);
        irq_shared[0] = 1'b0;
        chkirq("R10 level drop", '0);
        chkrd("R10 level pending gone", 0, 12'h204, 32'h0);
    endtask

    task automatic t_edge;
        wr(0, 12'h104, 32'h3);
        @(negedge clk);
        irq_shared[1] = 1'b1;
        @(negedge clk);
        chkirq("R11 edge line to cpu1", 4'b0010);
        irq_shared[1] = 1'b0;
        @(negedge clk);
        chkirq("R10 edge held after input low", 4'b0010);
        chkrd("R10 edge pending word", 0, 12'h204, 32'h2);
        wr(0, 12'h284, 32'h2);
        chkirq("R10 cleared by write", '0);
        chkrd("R10 pending after clear", 0, 12'h204, 32'h0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        reg_cpu = 0; reg_addr = 12'h284; reg_wdata = 32'h2; reg_wr = 1'b1;
        irq_shared[1] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chkirq("R12 edge beats clear irq", 4'b0010);
        chkrd("R12 edge beats clear pending", 0, 12'h204, 32'h2);
        wr(0, 12'h284, 32'h2);
        chkrd("R12 later clear works", 0, 12'h204, 32'h0);
        irq_shared[1] = 1'b0;
    endtask

    task automatic t_private;
        wr(3, 12'h100, 32'h0010_0000);
        @(negedge clk);
        irq_local[3*32+20] = 1'b1;
        chkirq("R4 private level to cpu3", 4'b1000);
        chkrd("R4 cpu0 copy untouched", 0, 12'h100, 32'h0);
        irq_local[3*32+20] = 1'b0;
        wr(0, 12'h100, 32'h0000_0020);
        @(negedge clk);
        irq_local[5] = 1'b1;
        @(negedge clk);
        irq_local[5] = 1'b0;
        chkirq("R11 private edge cpu0", 4'b0001);
        chkrd("R4 cpu0 pending", 0, 12'h200, 32'h20);
        chkrd("R4 cpu1 pending separate", 1, 12'h200, 32'h0);
        wr(0, 12'h000, 32'h0);
        chkirq("R9 switched off with pending", '0);
        wr(0, 12'h000, 32'h1);
        chkirq("R9 switched on again", 4'b0001);
        wr(0, 12'h280, 32'h20);
        chkirq("R10 private clear", '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_type();
        t_enable();
        t_bank();
        t_cfg();
        t_prio();
        t_target();
        t_level();
        t_edge();
        t_same_cycle();
        t_private();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule